// File: doc/BRIEF.md
# Reset Cause Capture

This block merges six reset requests into one stretched system reset and keeps a byte of sticky flags that tells software which requests caused it. The sources are the external reset pin, power-on detect, brownout detect, the watchdog, a software request and a serial-line break detector. Each one reaches the block as a digital request level. The analog detectors, the watchdog counter and the receiver are outside the block.

A power-on event replaces the flags with a fixed pattern: the power-on and brownout flags are set and all others are cleared. Any other accepted request sets its own flag and leaves earlier flags in place, so several flags can be set together. Software clears flags through a write port by writing 0 to a bit. Writing 1 to a bit does nothing.

The external pin is not always accepted. It is taken outside power-up only when a configuration input enables it. After the last accepted request goes away, the system reset stays asserted for a fixed number of cycles.

Top module: `reset_cause_capture`

## Requirements
- R1: Flag layout of `flags_o` and of `src_req`: bit0 external pin, bit1 software, bit2 watchdog, bit3 brownout, bit4 power-on, bit5 break detect. Bits 7:6 of `flags_o` always read 0. Flags change on the clock edge that samples the request.
- R2: An edge that samples `src_req[4]` high loads `flags_o` with 8'h18. This holds whatever other requests or writes are present in the same cycle.
- R3: With no power-on request, each accepted request sets its flag and keeps every other flag. Several requests in one cycle set all of their flags.
- R4: A write (`wr_en`=1) clears each flag whose `wr_data` bit is 0. A `wr_data` bit of 1 leaves that flag unchanged, so a write never sets a flag.
- R5: When a request and a write that clears its flag fall on the same edge, the flag ends up set.
- R6: A flag is cleared only by a write, by power-on or by `rst_n`. Other resets and the stretched reset never clear flags.
- R7: `sys_rst_o` is high in the cycle after any accepted request is sampled. It goes low exactly STRETCH (default 16) edges after the last edge that sampled an accepted request.
- R8: The external pin request is accepted only in one of three cases: `ext_cfg_en` is 1, a power-on request is present, or `sys_rst_o` is still high from a reset sequence started by power-on. Otherwise it is ignored: no flag is set and no reset is produced.
- R9: While `rst_n` is low, `flags_o` is 0 and `sys_rst_o` is 0. Both take these values asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's own state |
| src_req | input | 6 | Reset request levels, laid out as in R1 |
| ext_cfg_en | input | 1 | Accept the external pin outside power-up |
| wr_en | input | 1 | Flag register write strobe |
| wr_data | input | 8 | Write data; a 0 bit clears that flag |
| flags_o | output | 8 | Sticky reset-cause flags (read port) |
| sys_rst_o | output | 1 | Stretched active-high system reset |

## Verification
Flag updates appear one cycle after the inputs are applied, so every vector is driven on a falling edge and `flags_o` is read on the next falling edge. The reset output rises on the same one-cycle schedule. Its release is checked at the two edges that matter: the bench counts STRETCH-1 rising edges after the last accepted request and expects high, then one more edge and expects low. Ignored external-pin requests are checked by watching both `flags_o` and `sys_rst_o` for several cycles after the pulse.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int NSRC   = 6;
  localparam int FLAG_W = 8;

  // Bit positions shared by the request vector and the flag byte
  localparam int IDX_EXT = 0;
  localparam int IDX_SW  = 1;
  localparam int IDX_WDT = 2;
  localparam int IDX_BOD = 3;
  localparam int IDX_POR = 4;
  localparam int IDX_BRK = 5;

  // Flag image loaded on a power-on event
  function automatic logic [FLAG_W-1:0] por_image();
    logic [FLAG_W-1:0] v;
    v = '0;
    v[IDX_POR] = 1'b1;
    v[IDX_BOD] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/rcc_req_qualify.sv
module rcc_req_qualify
  import rcc_pkg::*;
#(
  parameter int NS = NSRC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] src_req,
  input  logic          ext_cfg_en,
  input  logic          sys_rst,
  output logic [NS-1:0] acc_req
);
  logic phase_q;
  logic phase_d;
  logic phase_en;
  logic ext_ok;

  // Power-up window: opened by power-on, held while its reset is asserted
  always_comb begin
    phase_d  = src_req[IDX_POR] | (phase_q & sys_rst);
    phase_en = src_req[IDX_POR] | phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
    end else if (phase_en) begin
      phase_q <= phase_d;
    end
  end

  assign ext_ok = ext_cfg_en | src_req[IDX_POR] | (phase_q & sys_rst);

  for (genvar g = 0; g < NS; g++) begin : g_q
    if (g == IDX_EXT) begin : g_ext
      assign acc_req[g] = src_req[g] & ext_ok;
    end else begin : g_pass
      assign acc_req[g] = src_req[g];
    end
  end
endmodule

// File: rtl/rcc_stretch.sv
module rcc_stretch #(
  parameter int STRETCH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic rst_o
);
  localparam int CW = $clog2(STRETCH + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          busy;

  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_en = trig | busy;
    if (trig) begin
      cnt_d = CW'(STRETCH);
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign rst_o = busy;
endmodule

// File: rtl/rcc_flag_reg.sv
module rcc_flag_reg
  import rcc_pkg::*;
#(
  parameter int FW = FLAG_W,
  parameter int NS = NSRC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] acc_req,
  input  logic          wr_en,
  input  logic [FW-1:0] wr_data,
  output logic [FW-1:0] flags
);
  localparam logic [FW-1:0] POR_IMG = por_image();

  logic por_ev;
  assign por_ev = acc_req[IDX_POR];

  for (genvar i = 0; i < FW; i++) begin : g_bit
    if (i < NS) begin : g_live
      logic q;
      logic d;
      logic en;
      logic clr;

      assign clr = wr_en & ~wr_data[i];

      always_comb begin
        en = por_ev | acc_req[i] | clr;
        if (por_ev) begin
          d = POR_IMG[i];
        end else if (acc_req[i]) begin
          d = 1'b1;
        end else begin
          d = 1'b0;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= 1'b0;
        end else if (en) begin
          q <= d;
        end
      end

      assign flags[i] = q;
    end else begin : g_rsvd
      assign flags[i] = 1'b0;
    end
  end
endmodule

// File: rtl/reset_cause_capture.sv
module reset_cause_capture
  import rcc_pkg::*;
#(
  parameter int STRETCH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_req,
  input  logic              ext_cfg_en,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_data,
  output logic [FLAG_W-1:0] flags_o,
  output logic              sys_rst_o
);
  logic [NSRC-1:0] acc_req;
  logic            any_acc;
  logic            rst_int;

  rcc_req_qualify #(.NS(NSRC)) u_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_req    (src_req),
    .ext_cfg_en (ext_cfg_en),
    .sys_rst    (rst_int),
    .acc_req    (acc_req)
  );

  assign any_acc = |acc_req;

  rcc_stretch #(.STRETCH(STRETCH)) u_str (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (any_acc),
    .rst_o (rst_int)
  );

  rcc_flag_reg #(.FW(FLAG_W), .NS(NSRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_req (acc_req),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .flags   (flags_o)
  );

  assign sys_rst_o = rst_int;
endmodule

// File: rtl/reset_cause_capture_chk.sv
module reset_cause_capture_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] src_req,
  input logic       ext_cfg_en,
  input logic       wr_en,
  input logic [7:0] flags_o,
  input logic       sys_rst_o
);
  AST_TOP_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[7:6] == 2'b00); // R1

  AST_POR_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
    src_req[4] |=> flags_o == 8'h18); // R2

  AST_SET_AND_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    !src_req[4] |=> ((flags_o[5:1] & $past(src_req[5:1])) == $past(src_req[5:1]))); // R5

  AST_NO_SET_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req == 6'b0) |=> ((flags_o & ~$past(flags_o)) == 8'h00)); // R4

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_req[4] && !wr_en) |=> ((flags_o & $past(flags_o)) == $past(flags_o))); // R6

  AST_RST_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_req[5:1]) |=> sys_rst_o); // R7

  AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_o) |-> $past(src_req[5:1] == 5'b0)); // R7

  AST_EXT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req == 6'b000001 && !ext_cfg_en && !sys_rst_o && !wr_en)
      |=> ($stable(flags_o) && !sys_rst_o)); // R8
endmodule

bind reset_cause_capture reset_cause_capture_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_req    (src_req),
  .ext_cfg_en (ext_cfg_en),
  .wr_en      (wr_en),
  .flags_o    (flags_o),
  .sys_rst_o  (sys_rst_o)
);

// File: tb/reset_cause_capture_tb_top.sv
`timescale 1ns/1ps
module reset_cause_capture_tb_top;
  logic       clk;
  logic       rst_n;
  logic [5:0] src_req;
  logic       ext_cfg_en;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] flags_o;
  logic       sys_rst_o;

  int checks;
  int errors;

  reset_cause_capture #(.STRETCH(16)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_req    (src_req),
    .ext_cfg_en (ext_cfg_en),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .flags_o    (flags_o),
    .sys_rst_o  (sys_rst_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Vector: {src_req[5:0], ext_cfg_en, wr_en, wr_data[7:0], expected flags[7:0]}
  localparam int NV = 14;
  localparam logic [23:0] VEC [NV] = '{
    {6'h10, 1'b1, 1'b0, 8'h00, 8'h18},  // R2 power-on image
    {6'h00, 1'b1, 1'b0, 8'h00, 8'h18},  // R6 idle hold
    {6'h04, 1'b1, 1'b0, 8'h00, 8'h1C},  // R3 watchdog adds
    {6'h00, 1'b1, 1'b1, 8'hF7, 8'h14},  // R4 clear brownout
    {6'h00, 1'b1, 1'b1, 8'hFF, 8'h14},  // R4 write ones no effect
    {6'h22, 1'b1, 1'b0, 8'h00, 8'h36},  // R3 two sources at once
    {6'h04, 1'b1, 1'b1, 8'h00, 8'h04},  // R5 set beats clear
    {6'h16, 1'b1, 1'b0, 8'h00, 8'h18},  // R2 power-on overrides others
    {6'h10, 1'b1, 1'b1, 8'h00, 8'h18},  // R2 power-on overrides write
    {6'h00, 1'b1, 1'b1, 8'h00, 8'h00},  // R4 clear all
    {6'h01, 1'b1, 1'b0, 8'h00, 8'h01},  // R8 external enabled
    {6'h08, 1'b1, 1'b0, 8'h00, 8'h09},  // R3 brownout adds
    {6'h00, 1'b1, 1'b1, 8'hC0, 8'h00},  // R1 R4 upper write bits inert
    {6'h20, 1'b1, 1'b0, 8'h00, 8'h20}   // R1 break flag position
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    src_req = '0; wr_en = 1'b0; wr_data = '0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; src_req = '0; ext_cfg_en = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    check("R9 reset flags", flags_o, 8'h00);
    check("R9 reset sysrst", {7'b0, sys_rst_o}, 8'h00);
    rst_n = 1'b1;
    idle(2);

    // R8: external pin ignored when not enabled and not in power-up
    ext_cfg_en = 1'b0; src_req = 6'h01;
    @(negedge clk);
    src_req = '0;
    check("R8 ext ignored flags", flags_o, 8'h00);
    check("R8 ext ignored sysrst", {7'b0, sys_rst_o}, 8'h00);
    @(negedge clk);
    check("R8 ext ignored sysrst later", {7'b0, sys_rst_o}, 8'h00);

    // R7: stretch after a 3-cycle watchdog request
    src_req = 6'h04;
    @(negedge clk);
    check("R7 rst rises", {7'b0, sys_rst_o}, 8'h01);
    repeat (2) @(negedge clk);
    src_req = '0;
    repeat (15) @(negedge clk);
    check("R7 rst held 15", {7'b0, sys_rst_o}, 8'h01);
    @(negedge clk);
    check("R7 rst released 16", {7'b0, sys_rst_o}, 8'h00);
    check("R3 watchdog flag", flags_o, 8'h04);
    wr_en = 1'b1; wr_data = 8'h00;
    @(negedge clk);
    check("R4 clear", flags_o, 8'h00);
    idle(2);

    // Vector table
    for (int k = 0; k < NV; k++) begin
      src_req    = VEC[k][23:18];
      ext_cfg_en = VEC[k][17];
      wr_en      = VEC[k][16];
      wr_data    = VEC[k][15:8];
      @(negedge clk);
      check($sformatf("R1-table vec%0d", k), flags_o, VEC[k][7:0]);
    end
    ext_cfg_en = 1'b0;
    idle(20);
    check("R6 flags kept after stretch", flags_o, 8'h20);

    // R8: external accepted during power-up window with enable off
    src_req = 6'h10;
    @(negedge clk);
    src_req = '0;
    @(negedge clk);
    src_req = 6'h01;
    @(negedge clk);
    src_req = '0;
    check("R8 ext in powerup flags", flags_o, 8'h19);
    repeat (15) @(negedge clk);
    check("R8 R7 ext extends rst", {7'b0, sys_rst_o}, 8'h01);
    @(negedge clk);
    check("R7 release after ext", {7'b0, sys_rst_o}, 8'h00);

    // R9: asynchronous reset mid-run
    src_req = 6'h02;
    @(negedge clk);
    src_req = '0;
    #1 rst_n = 1'b0;
    #0.5;
    check("R9 async flags", flags_o, 8'h00);
    check("R9 async sysrst", {7'b0, sys_rst_o}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule